// File: doc/BRIEF.md
# In-Order Work-Group Dealer

This block takes the numbered work-groups of one kernel and hands them, one at a time and in strictly increasing index order, to four engine groups. Each engine group owns fifteen compute units. A flat unit mask chooses which units the kernel may use. The dealer works like dealing cards. Block N goes to the current engine, and block N+1 goes to the next eligible engine in cyclic order. An engine is eligible when its part of the mask enables at least one unit.

The dealer never passes over an eligible engine that is busy. If the engine whose turn it is does not accept, the dealer keeps offering the same block to that engine. All other engines wait, even when they are ready. A kernel is started with a one-cycle `start` pulse. The block count and the mask are captured at that pulse. A one-cycle `done` pulse follows the acceptance of the last block. A mask that enables no unit at all raises a one-cycle `mask_err` pulse, and no block is dispatched.

Top module: `block_dealer`

## Requirements
- R1: After reset, `eng_valid`, `done` and `mask_err` are all 0.
- R2: At most one bit of `eng_valid` is high at a time. Accepted block indices run 0, 1, 2, … up to the block count minus 1, and each index appears exactly once.
- R3: After block N is accepted on engine e, block N+1 is offered to the first eligible engine after e in the order 0, 1, 2, 3, 0, …
- R4: While the offered engine holds its `eng_ready` bit low, the same engine bit and the same block index stay presented. No other engine receives a block in that time, even one whose ready bit is high.
- R5: An engine whose fifteen mask bits are all 0 never sees `eng_valid`. An engine with at least one enabled unit stays in the rotation.
- R6: Flat mask bit i belongs to engine i mod 4, unit i div 4. The engine-e slice `eng_mask[e*15 +: 15]` has its bit u equal to `unit_mask[u*4+e]`.
- R7: The first block of every kernel goes to the lowest-numbered eligible engine.
- R8: If the mask enables no unit, `mask_err` pulses for exactly one cycle, in the cycle after `start`. In that case no block is offered and `done` stays low.
- R9: `done` is high for exactly one cycle, the cycle after the last block is accepted. With a block count of 0, `done` is high in the cycle after `start` and no block is offered.
- R10: The block count and the mask are captured only at `start`. A `start` pulse or a mask change during a running kernel has no effect on the blocks, engines or mask slices dealt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle kernel start |
| total_blocks | input | 16 | Number of blocks in the kernel |
| unit_mask | input | 60 | Flat unit mask, bit i = engine i mod 4, unit i div 4 |
| eng_ready | input | 4 | Per-engine accept |
| eng_valid | output | 4 | Per-engine block offer |
| eng_block | output | 64 | Per-engine block index, 16 bits per engine |
| eng_mask | output | 60 | Per-engine unit-mask slices, 15 bits per engine |
| done | output | 1 | One-cycle pulse after the last block is accepted |
| mask_err | output | 1 | One-cycle pulse when the mask enables no unit |

## Verification
The bench runs the following cases:
- A full mask with every engine always ready. This shows the plain 0-1-2-3 wrap.
- Masks that empty one or more engines. These separate correct skipping from a fixed modulo-4 order.
- A mask with the lowest engines empty. This exposes a wrong start position.
- A pseudo-random ready pattern, which stalls the offered engine while others are ready. This separates head-of-line waiting from a greedy pick of any ready engine.
- An empty mask, a zero block count, and a restart plus a mask change in mid-kernel. These cover the error pulse, the done pulse and the capture of inputs at start.

// File: rtl/block_dealer.sv
module block_dealer #(
  parameter int NUM_ENG = 4,
  parameter int UNITS   = 15,
  parameter int CNT_W   = 16,
  localparam int MASK_W = NUM_ENG * UNITS,
  localparam int PTR_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         total_blocks,
  input  logic [MASK_W-1:0]        unit_mask,
  input  logic [NUM_ENG-1:0]       eng_ready,
  output logic [NUM_ENG-1:0]       eng_valid,
  output logic [NUM_ENG*CNT_W-1:0] eng_block,
  output logic [MASK_W-1:0]        eng_mask,
  output logic                     done,
  output logic                     mask_err
);

  logic              busy;
  logic [PTR_W-1:0]  ptr;
  logic [CNT_W-1:0]  idx, total_q;
  logic [MASK_W-1:0] grp, mask_q;
  logic [NUM_ENG-1:0] elig_in, elig_q;

  function automatic logic [PTR_W-1:0] next_elig(input logic [NUM_ENG-1:0] el,
                                                 input logic [PTR_W-1:0] cur);
    logic [PTR_W-1:0] res;
    logic found;
    res = cur;
    found = 1'b0;
    for (int k = 1; k <= NUM_ENG; k++) begin
      int j;
      j = (int'(cur) + k) % NUM_ENG;
      if (!found && el[j]) begin
        res = PTR_W'(j);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      assign grp[e*UNITS+u] = unit_mask[u*NUM_ENG+e];
    end
    assign elig_in[e]               = |grp[e*UNITS +: UNITS];
    assign elig_q[e]                = |mask_q[e*UNITS +: UNITS];
    assign eng_valid[e]             = busy && (ptr == PTR_W'(e));
    assign eng_block[e*CNT_W +: CNT_W] = idx;
  end

  assign eng_mask = mask_q;

  wire accept = busy && eng_ready[ptr];
  wire last   = (idx == total_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ptr      <= '0;
      idx      <= '0;
      total_q  <= '0;
      mask_q   <= '0;
      done     <= 1'b0;
      mask_err <= 1'b0;
    end else begin
      done     <= 1'b0;
      mask_err <= 1'b0;
      if (!busy && start) begin
        if (elig_in == '0) begin
          mask_err <= 1'b1;
        end else if (total_blocks == '0) begin
          done <= 1'b1;
        end else begin
          busy    <= 1'b1;
          ptr     <= next_elig(elig_in, PTR_W'(NUM_ENG-1));
          idx     <= '0;
          total_q <= total_blocks;
          mask_q  <= grp;
        end
      end else if (accept) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          ptr <= next_elig(elig_q, ptr);
        end
      end
    end
  end

  AST_ONE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid)); // R2
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eng_valid & ~eng_ready)) |=> $stable(eng_valid) && $stable(idx)); // R4
  AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid & ~elig_q) == '0); // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last) |=> idx == $past(idx) + 1'b1); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err |-> (eng_valid == '0 && !done)); // R8

endmodule

// File: tb/tb_block_dealer.sv
module tb_block_dealer;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] total_blocks = 0;
  logic [59:0] unit_mask = 0;
  logic [3:0]  eng_ready = 0;
  logic [3:0]  eng_valid;
  logic [63:0] eng_block;
  logic [59:0] eng_mask;
  logic done, mask_err;

  block_dealer dut (.clk, .rst_n, .start, .total_blocks, .unit_mask, .eng_ready,
                    .eng_valid, .eng_block, .eng_mask, .done, .mask_err);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, ncyc = 0, last_acc = -10;
  int qe[$], qi[$];
  int done_cnt = 0, err_cnt = 0;
  logic [59:0] cur_mask = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit rand_ready = 0;
  bit prev_stall = 0;
  int prev_e = 0, prev_i = 0;
  int exp_total = 0;

  task automatic chk(bit ok, string req, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, msg, act, exp);
    end
  endtask

  function automatic logic [14:0] slice_of(logic [59:0] m, int e);
    logic [14:0] s;
    for (int u = 0; u < 15; u++) s[u] = m[u*4+e];
    return s;
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]};
    eng_ready <= rand_ready ? (lfsr[3:0] | {lfsr[8], 3'b0}) : 4'hF;
  end

  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      int e;
      e = 0;
      for (int k = 0; k < 4; k++) if (eng_valid[k]) e = k;
      if (prev_stall) begin
        chk(eng_valid == (4'b1 << prev_e) && int'(eng_block[prev_e*16 +: 16]) == prev_i,
            "R4", "offer not held", int'(eng_valid), 1 << prev_e);
      end
      prev_stall = (eng_valid != 0) && !eng_ready[e];
      prev_e = e;
      prev_i = int'(eng_block[e*16 +: 16]);
      if (eng_valid != 0 && eng_ready[e]) begin
        if (qe.size() == 0) begin
          chk(0, "R2", "unexpected dispatch engine", e, -1);
        end else begin
          int xe, xi;
          xe = qe.pop_front();
          xi = qi.pop_front();
          chk(e == xe, "R3", "engine", e, xe);
          chk(int'(eng_block[e*16 +: 16]) == xi, "R2", "block index", int'(eng_block[e*16 +: 16]), xi);
          chk(eng_mask[e*15 +: 15] == slice_of(cur_mask, e), "R6", "mask slice",
              int'(eng_mask[e*15 +: 15]), int'(slice_of(cur_mask, e)));
        end
        last_acc = ncyc;
      end
      if (done) begin
        done_cnt++;
        chk(qe.size() == 0, "R9", "done with blocks pending", qe.size(), 0);
        if (exp_total > 0) chk(last_acc == ncyc - 1, "R9", "done timing", ncyc - last_acc, 1);
      end
      if (mask_err) err_cnt++;
    end
  end

  task automatic run_kernel(int total, logic [59:0] m, bit midstart);
    logic [3:0] el;
    int e, w;
    bit exp_err;
    for (int k = 0; k < 4; k++) el[k] = |slice_of(m, k);
    exp_err = (el == 0);
    cur_mask = m;
    exp_total = total;
    if (!exp_err) begin
      e = 0;
      while (!el[e]) e++;
      for (int b = 0; b < total; b++) begin
        qe.push_back(e); qi.push_back(b);
        e = (e + 1) % 4;
        while (!el[e]) e = (e + 1) % 4;
      end
    end
    done_cnt = 0; err_cnt = 0;
    @(negedge clk);
    total_blocks = 16'(total); unit_mask = m; start = 1;
    @(negedge clk);
    start = 0;
    if (midstart) begin
      repeat (3) @(negedge clk);
      unit_mask = ~m; total_blocks = 2; start = 1;
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (done_cnt == 0 && err_cnt == 0 && w < 3000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    if (exp_err) begin
      chk(err_cnt == 1 && done_cnt == 0, "R8", "error pulses", err_cnt, 1);
    end else begin
      chk(done_cnt == 1 && err_cnt == 0, "R9", "done pulses", done_cnt, 1);
      chk(qe.size() == 0, midstart ? "R10" : "R2", "blocks left", qe.size(), 0);
    end
    qe.delete(); qi.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [59:0] m;
    repeat (3) @(negedge clk);
    chk(eng_valid == 0 && !done && !mask_err, "R1", "reset outputs", int'(eng_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(eng_valid == 0 && !done && !mask_err, "R1", "idle after reset", int'(eng_valid), 0);
    run_kernel(9, {60{1'b1}}, 0);                     // R3 plain wrap
    rand_ready = 1;
    run_kernel(13, {60{1'b1}}, 0);                    // R4 random stalls
    m = {60{1'b1}};
    for (int u = 0; u < 15; u++) m[u*4+1] = 0;
    run_kernel(11, m, 0);                             // R5 engine 1 empty
    m = 0; m[59] = 1; m[2] = 1;
    run_kernel(7, m, 0);                              // R7 start at engine 2
    m = 0; m[5] = 1;
    run_kernel(5, m, 0);                              // R5 single engine
    run_kernel(4, 60'h0, 0);                          // R8
    run_kernel(0, {60{1'b1}}, 0);                     // R9 zero count
    m = 60'h0F0_0000_0000_1234;
    run_kernel(20, m, 1);                             // R10 restart ignored
    run_kernel(3, 60'h0, 0);                          // R8 again
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule